// File: doc/BRIEF.md
# Pseudo Bit-Error-Rate Measurement Controller

This block measures a bit error rate from a stream of received bits. Each received bit arrives as a one-cycle strobe together with an error flag, which an offset-sampling comparator outside the block produces. Once a measurement is launched, the block counts strobed bits until a programmable total is reached. Over the same bits it adds up the flagged errors in a saturating accumulator. When the total is reached, a done flag rises and the result is frozen.

Software reads the result one byte at a time through a byte selector. The bit stream is a valid-only stream with no back-pressure: every beat with the valid strobe high is consumed in that cycle, as long as a measurement is running and the monitor is active. Beats at any other time are dropped.

The bit total is 2^(BASE_EXP + STEP_EXP*k), where k is the 3-bit timer code. With the default parameters this gives totals from 2^18 to 2^39 in steps of 2^3.

Top module: `pberm_ctrl`

## Requirements
- R1: After reset, meas_done is 0 and every byte select code returns 0x00.
- R2: A measurement starts only when start_ctl goes from 1 back to 0 while mon_en is 1. Holding start_ctl at 1 starts nothing. The start clears the bit counter, the error accumulator and meas_done by the following cycle.
- R3: meas_done rises in the cycle after the accepted beat that brings the bit count to 2^(BASE_EXP + STEP_EXP*k). It does not rise earlier. Here k is the value of timer_sel (0 to 7).
- R4: A cycle with bit_vld at 0 is neither counted nor able to add an error, whatever bit_err is.
- R5: Each accepted beat with bit_err at 1 adds one to the error count. This includes the beat that completes the measurement.
- R6: The error count stays at all ones (ERR_W bits) once it reaches that value, instead of wrapping.
- R7: After meas_done is set, it stays at 1 and the error count holds until the next start. Beats and error flags in that time are ignored.
- R8: The result is the error count zero-extended to 40 bits. byte_sel code n (0 to 4) returns bits 8n+7 down to 8n; for example, code 3 returns bits 31..24. Codes 5, 6 and 7 return 0x00.
- R9: While mon_stby is 1 or mon_en is 0, beats are ignored and the bit count holds. A start is accepted whenever mon_en is 1, whatever mon_stby is. A start while mon_en is 0 is ignored.
- R10: timer_sel is captured at the start. Changing it during a measurement has no effect on that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Monitor enable |
| mon_stby | input | 1 | Standby; pauses counting while 1 |
| start_ctl | input | 1 | Start control; a 1 followed by 0 launches a run |
| timer_sel | input | 3 | Bit-total code k |
| byte_sel | input | 3 | Result byte selector |
| bit_vld | input | 1 | Per-bit valid strobe |
| bit_err | input | 1 | Per-bit error flag, qualified by bit_vld |
| rd_byte | output | 8 | Selected byte of the error count |
| meas_done | output | 1 | End-of-measurement flag |

## Verification
The bench builds the block with BASE_EXP=4, STEP_EXP=1 and ERR_W=10, so the bit totals run from 16 to 2048 beats. With these values every timer code can be run to completion in a few thousand cycles. Because the accumulator is only 10 bits wide, a run of 2048 all-error beats drives it into saturation, and its value 0x3FF spreads over two readback bytes, so the byte ordering is checked as well. The start edge, standby, disable, timer capture and post-done behaviour are each driven as a separate directed scenario.

// File: rtl/pberm_pkg.sv
package pberm_pkg;
  localparam int SEL_W      = 3;
  localparam int TERM_CODES = 1 << SEL_W;
  localparam int RES_BYTES  = 5;
  localparam int RES_W      = 8 * RES_BYTES;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } meas_state_t;
endpackage

// File: rtl/pberm_start_det.sv
module pberm_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_en,
  input  logic ctl,
  output logic start_o
);
  logic ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= 1'b0;
    else        ctl_q <= ctl;
  end

  // launch on the 1 -> 0 return of the control bit
  assign start_o = arm_en & ctl_q & ~ctl;
endmodule

// File: rtl/pberm_bit_timer.sv
module pberm_bit_timer
  import pberm_pkg::*;
#(
  parameter int BASE_EXP = 18,
  parameter int STEP_EXP = 3,
  parameter int CNT_W    = BASE_EXP + STEP_EXP * (TERM_CODES - 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] term_tab [TERM_CODES];
  logic [CNT_W-1:0] term_q;
  logic [CNT_W-1:0] cnt_q;

  for (genvar k = 0; k < TERM_CODES; k++) begin : g_term
    assign term_tab[k] = CNT_W'(1) << (BASE_EXP + STEP_EXP * k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= '0;
    end else if (clear) begin
      cnt_q  <= '0;
      term_q <= term_tab[sel_i];
    end else if (adv) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign hit_o = adv && ((cnt_q + CNT_W'(1)) == term_q);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pberm_err_accum.sv
module pberm_err_accum #(
  parameter int ERR_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [ERR_W-1:0] acc_o
);
  logic [ERR_W-1:0] acc_q;
  logic             full;

  assign full = &acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             acc_q <= '0;
    else if (clear)         acc_q <= '0;
    else if (inc && !full)  acc_q <= acc_q + ERR_W'(1);
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/pberm_byte_sel.sv
module pberm_byte_sel
  import pberm_pkg::*;
#(
  parameter int ERR_W = 40
) (
  input  logic [ERR_W-1:0] acc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [7:0]       byte_o
);
  logic [RES_W-1:0] res;
  logic [7:0]       byte_arr [RES_BYTES];

  assign res = RES_W'(acc_i);

  for (genvar g = 0; g < RES_BYTES; g++) begin : g_byte
    assign byte_arr[g] = res[8*g +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < RES_BYTES; i++) begin
      if (sel_i == SEL_W'(i)) byte_o = byte_arr[i];
    end
  end
endmodule

// File: rtl/pberm_ctrl.sv
module pberm_ctrl
  import pberm_pkg::*;
#(
  parameter int BASE_EXP = 18,
  parameter int STEP_EXP = 3,
  parameter int ERR_W    = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mon_en,
  input  logic       mon_stby,
  input  logic       start_ctl,
  input  logic [2:0] timer_sel,
  input  logic [2:0] byte_sel,
  input  logic       bit_vld,
  input  logic       bit_err,
  output logic [7:0] rd_byte,
  output logic       meas_done
);
  localparam int CNT_W = BASE_EXP + STEP_EXP * (TERM_CODES - 1) + 1;

  meas_state_t      state_q;
  logic             start_pulse;
  logic             active;
  logic             adv;
  logic             inc;
  logic             hit;
  logic [CNT_W-1:0] bit_cnt;
  logic [ERR_W-1:0] err_acc;

  pberm_start_det u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_en  (mon_en),
    .ctl     (start_ctl),
    .start_o (start_pulse)
  );

  assign active = mon_en & ~mon_stby;
  assign adv    = (state_q == ST_RUN) & active & bit_vld;
  assign inc    = adv & bit_err;

  pberm_bit_timer #(
    .BASE_EXP (BASE_EXP),
    .STEP_EXP (STEP_EXP),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_pulse),
    .adv   (adv),
    .sel_i (timer_sel),
    .hit_o (hit),
    .cnt_o (bit_cnt)
  );

  pberm_err_accum #(.ERR_W(ERR_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_pulse),
    .inc   (inc),
    .acc_o (err_acc)
  );

  pberm_byte_sel #(.ERR_W(ERR_W)) u_rdmux (
    .acc_i  (err_acc),
    .sel_i  (byte_sel),
    .byte_o (rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           state_q <= ST_IDLE;
    else if (start_pulse) state_q <= ST_RUN;
    else if (hit)         state_q <= ST_DONE;
  end

  assign meas_done = (state_q == ST_DONE);
endmodule

// File: rtl/pberm_ctrl_chk.sv
module pberm_ctrl_chk #(
  parameter int ERR_W = 40,
  parameter int CNT_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mon_en,
  input logic             mon_stby,
  input logic             start_ctl,
  input logic [2:0]       byte_sel,
  input logic [7:0]       rd_byte,
  input logic             meas_done,
  input logic [ERR_W-1:0] err_acc,
  input logic [CNT_W-1:0] bit_cnt
);
  logic ctl_seen;
  logic st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_seen <= 1'b0;
    else        ctl_seen <= start_ctl;
  end

  assign st = mon_en && ctl_seen && !start_ctl;

  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st |=> (err_acc == '0 && bit_cnt == '0 && !meas_done));

  assert_acc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !st |=> (err_acc == $past(err_acc) || err_acc == $past(err_acc) + ERR_W'(1)));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&err_acc && !st) |=> &err_acc);

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && !st) |=> meas_done);

  assert_acc_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && !st) |=> $stable(err_acc));

  assert_high_sel_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_sel > 3'd4) |-> (rd_byte == 8'h00));

  assert_stby_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mon_stby || !mon_en) && !st) |=> $stable(bit_cnt));
endmodule

bind pberm_ctrl pberm_ctrl_chk #(
  .ERR_W (ERR_W),
  .CNT_W (CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mon_en    (mon_en),
  .mon_stby  (mon_stby),
  .start_ctl (start_ctl),
  .byte_sel  (byte_sel),
  .rd_byte   (rd_byte),
  .meas_done (meas_done),
  .err_acc   (err_acc),
  .bit_cnt   (bit_cnt)
);

// File: tb/pberm_ctrl_tb_top.sv
`timescale 1ns/1ps
module pberm_ctrl_tb_top;
  localparam int BASE = 4;
  localparam int STEP = 1;
  localparam int EW   = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mon_en = 1'b1;
  logic       mon_stby = 1'b0;
  logic       start_ctl = 1'b0;
  logic [2:0] timer_sel = 3'd0;
  logic [2:0] byte_sel = 3'd0;
  logic       bit_vld = 1'b0;
  logic       bit_err = 1'b0;
  logic [7:0] rd_byte;
  logic       meas_done;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pberm_ctrl #(.BASE_EXP(BASE), .STEP_EXP(STEP), .ERR_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .mon_stby(mon_stby),
    .start_ctl(start_ctl), .timer_sel(timer_sel), .byte_sel(byte_sel),
    .bit_vld(bit_vld), .bit_err(bit_err), .rd_byte(rd_byte), .meas_done(meas_done)
  );

  function automatic int total(input int k);
    return 1 << (BASE + STEP * k);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic read_byte(input int sel, output logic [7:0] val);
    @(negedge clk);
    byte_sel = sel[2:0];
    #2;
    val = rd_byte;
  endtask

  task automatic check_byte(input string req, input int sel, input int exp);
    logic [7:0] v;
    read_byte(sel, v);
    check(req, v, exp);
  endtask

  // mode 0: no errors, 1: every beat errored, 2: even-index beats errored
  task automatic beats(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 1'b1;
      bit_err = (mode == 1) || (mode == 2 && (i % 2) == 0);
    end
    @(negedge clk);
    bit_vld = 1'b0;
    bit_err = 1'b0;
  endtask

  task automatic do_start(input int k);
    @(negedge clk);
    timer_sel = k[2:0];
    start_ctl = 1'b1;
    @(negedge clk);
    start_ctl = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 done after reset", meas_done, 0);
    for (int s = 0; s < 5; s++) check_byte("R1 byte after reset", s, 0);
  endtask

  task automatic t_basic;
    do_start(0);
    beats(15, 2);                  // 8 errors over 15 beats
    for (int i = 0; i < 3; i++) begin // R4: invalid cycles carrying errors
      @(negedge clk);
      bit_vld = 1'b0;
      bit_err = 1'b1;
    end
    @(negedge clk);
    bit_err = 1'b0;
    check("R3 done early", meas_done, 0);
    check_byte("R4 unqualified errors", 0, 8);
    beats(1, 1);
    check("R3 done at total", meas_done, 1);
    check_byte("R5 error count incl last beat", 0, 9);
  endtask

  task automatic t_after_done;
    beats(5, 1);
    check("R7 done held", meas_done, 1);
    check_byte("R7 count frozen", 0, 9);
  endtask

  task automatic t_restart;
    @(negedge clk);
    start_ctl = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 held 1 does not start", meas_done, 1);
    start_ctl = 1'b0;
    @(negedge clk);
    check("R2 start clears done", meas_done, 0);
    check_byte("R2 start clears count", 0, 0);
    beats(16, 0);
    check("R3 done k0 no errors", meas_done, 1);
    check_byte("R5 zero errors", 0, 0);
  endtask

  task automatic t_timer_capture;
    do_start(1);
    @(negedge clk);
    timer_sel = 3'd0;
    beats(16, 1);
    check("R10 mid-run timer change ignored", meas_done, 0);
    beats(total(1) - 16, 1);
    check("R10 done at captured total", meas_done, 1);
    check_byte("R5 count k1", 0, 32);
  endtask

  task automatic t_larger;
    do_start(3);
    beats(total(3) - 1, 2);
    check("R3 done early k3", meas_done, 0);
    beats(1, 0);
    check("R3 done k3", meas_done, 1);
    check_byte("R5 count k3", 0, 64);
  endtask

  task automatic t_standby;
    do_start(0);
    beats(8, 1);
    @(negedge clk);
    mon_stby = 1'b1;
    beats(8, 1);
    check("R9 standby beats ignored", meas_done, 0);
    check_byte("R9 standby errors ignored", 0, 8);
    @(negedge clk);
    mon_stby = 1'b0;
    mon_en = 1'b0;
    beats(8, 1);
    check("R9 disabled beats ignored", meas_done, 0);
    check_byte("R9 disabled errors ignored", 0, 8);
    @(negedge clk);
    mon_en = 1'b1;
    beats(8, 0);
    check("R9 resume completes", meas_done, 1);
    check_byte("R9 count after resume", 0, 8);
    @(negedge clk);
    mon_en = 1'b0;
    start_ctl = 1'b1;
    @(negedge clk);
    start_ctl = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 start ignored when disabled", meas_done, 1);
    mon_en = 1'b1;
  endtask

  task automatic t_saturate;
    do_start(7);
    beats(total(7), 1);
    check("R3 done k7", meas_done, 1);
    check_byte("R6 saturated low byte", 0, 8'hFF);
    check_byte("R8 byte 1", 1, 8'h03);
    check_byte("R8 byte 2", 2, 0);
    check_byte("R8 byte 3", 3, 0);
    check_byte("R8 byte 4", 4, 0);
    for (int s = 5; s < 8; s++) check_byte("R8 unused select", s, 0);
  endtask

  initial begin
    #(20 * 60000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_after_done();
    t_restart();
    t_timer_capture();
    t_larger();
    t_standby();
    t_saturate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule